// File: doc/BRIEF.md
# Dual-Read General-Purpose Register File with Word Pointers

This block is the working-register store of a small 8-bit processor. It holds thirty-two byte-wide registers. Two independent combinational read ports supply the operands to the arithmetic unit, and one synchronous byte write port stores the result. Operand fetch, execution and writeback therefore fit inside a single clock period. When an operation needs only one operand, the second read port can be left unused.

The six highest registers are also seen as three 16-bit address pointers, called here P0, P1 and P2. A word port reads and writes each pointer, so post-increment and pre-decrement addressing can update both bytes of a pointer on one clock edge. Pointer P2 is also driven without interruption onto a dedicated output, which is used as the address for constant-table reads from program memory.

Top module: `gpr_file`

## Requirements
- R1: A synchronous reset (`rst`, active high) clears all 32 registers to 0x00 on the next rising clock edge.
- R2: The two read ports are combinational and independent. `rd_a_data` always equals the register selected by `rd_a_sel`, and `rd_b_data` always equals the register selected by `rd_b_sel`. Both ports may select the same register.
- R3: When `wr_en` is high, `wr_data` is stored into the register selected by `wr_sel` at the rising edge. A read of that register in the same cycle returns the old value, and the new value appears in the next cycle.
- R4: Pointer encoding: `ptr_sel` 0 selects P0 = {r27,r26}, 1 selects P1 = {r29,r28}, and 2 selects P2 = {r31,r30}, with the high byte in bits 15:8. The code 3 selects no pointer: a read returns 0x0000 and a write has no effect.
- R5: `ptr_rd_data` combinationally returns the selected pointer as a word, so it reflects earlier byte writes to its two registers.
- R6: When `ptr_wr_en` is high, `ptr_wr_data` updates both bytes of the selected pair on the same edge. The new bytes are then visible on the byte read ports.
- R7: If a byte write and a pointer write hit the same register in one cycle, the pointer write value is kept. A byte write to a different register in the same cycle still takes effect.
- R8: `lut_addr` always equals {r31,r30}.
- R9: When no write enable is high, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_sel | input | 5 | Read port A register index |
| rd_a_data | output | 8 | Read port A data |
| rd_b_sel | input | 5 | Read port B register index |
| rd_b_data | output | 8 | Read port B data |
| wr_en | input | 1 | Byte write enable |
| wr_sel | input | 5 | Byte write register index |
| wr_data | input | 8 | Byte write data |
| ptr_sel | input | 2 | Pointer select (0,1,2; 3 none) |
| ptr_rd_data | output | 16 | Selected pointer word |
| ptr_wr_en | input | 1 | Pointer word write enable |
| ptr_wr_data | input | 16 | Pointer word write data |
| lut_addr | output | 16 | Program-memory table address from P2 |

## Verification
Random mixes of byte writes, pointer writes, idle cycles and reads from both ports are compared with a bench model of the registers. The mix includes cycles where both ports select the same register, which would expose crossed port wiring. Directed cases cover byte writes into pointer registers that must then show in the word read, and pointer writes that must then show in byte reads; together these show the high/low byte order in both directions. Another directed case is a same-cycle byte write and pointer write to one register, plus the same pair aimed at different registers, which tells the priority rule apart from a write that blocks the other. Reads taken in the write cycle separate old-value read-during-write from bypass.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
    localparam int unsigned NREG  = 32;
    localparam int unsigned DW    = 8;
    localparam int unsigned AW    = $clog2(NREG);
    localparam int unsigned NPTR  = 3;
    localparam int unsigned PW    = 2 * DW;
    localparam int unsigned PBASE = NREG - 2 * NPTR;

    typedef logic [DW-1:0] byte_t;
    typedef logic [AW-1:0] idx_t;
    typedef logic [PW-1:0] word_t;

    typedef struct packed {
        byte_t [NREG-1:0] regs;
    } gpr_state_t;
endpackage

// File: rtl/gpr_ptr_view.sv
module gpr_ptr_view
    import gpr_pkg::*;
(
    input  byte_t [NREG-1:0] regs_i,
    input  logic  [1:0]      sel_i,
    output word_t            word_o,
    output word_t            lut_o
);
    word_t [NPTR-1:0] pw;

    for (genvar p = 0; p < NPTR; p++) begin : g_pair
        assign pw[p] = {regs_i[PBASE + 2*p + 1], regs_i[PBASE + 2*p]};
    end

    always_comb begin
        word_o = '0;
        if (int'(sel_i) < NPTR) word_o = pw[sel_i];
    end

    assign lut_o = pw[NPTR-1];
endmodule

// File: rtl/gpr_next.sv
module gpr_next
    import gpr_pkg::*;
(
    input  logic             rst_i,
    input  byte_t [NREG-1:0] regs_q_i,
    input  logic             wr_en_i,
    input  idx_t             wr_sel_i,
    input  byte_t            wr_data_i,
    input  logic             ptr_wr_en_i,
    input  logic  [1:0]      ptr_sel_i,
    input  word_t            ptr_wr_data_i,
    output byte_t [NREG-1:0] regs_d_o
);
    always_comb begin
        regs_d_o = regs_q_i;
        if (wr_en_i) regs_d_o[wr_sel_i] = wr_data_i;
        if (ptr_wr_en_i && int'(ptr_sel_i) < NPTR) begin
            regs_d_o[PBASE + 2*int'(ptr_sel_i)]     = ptr_wr_data_i[DW-1:0];
            regs_d_o[PBASE + 2*int'(ptr_sel_i) + 1] = ptr_wr_data_i[PW-1:DW];
        end
        if (rst_i) regs_d_o = '0;
    end
endmodule

// File: rtl/gpr_file.sv
module gpr_file
    import gpr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  rd_a_sel,
    output logic [7:0]  rd_a_data,
    input  logic [4:0]  rd_b_sel,
    output logic [7:0]  rd_b_data,
    input  logic        wr_en,
    input  logic [4:0]  wr_sel,
    input  logic [7:0]  wr_data,
    input  logic [1:0]  ptr_sel,
    output logic [15:0] ptr_rd_data,
    input  logic        ptr_wr_en,
    input  logic [15:0] ptr_wr_data,
    output logic [15:0] lut_addr
);
    gpr_state_t st_d, st_q;

    gpr_next u_next (
        .rst_i        (rst),
        .regs_q_i     (st_q.regs),
        .wr_en_i      (wr_en),
        .wr_sel_i     (wr_sel),
        .wr_data_i    (wr_data),
        .ptr_wr_en_i  (ptr_wr_en),
        .ptr_sel_i    (ptr_sel),
        .ptr_wr_data_i(ptr_wr_data),
        .regs_d_o     (st_d.regs)
    );

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rd_a_data = st_q.regs[rd_a_sel];
    assign rd_b_data = st_q.regs[rd_b_sel];

    gpr_ptr_view u_view (
        .regs_i(st_q.regs),
        .sel_i (ptr_sel),
        .word_o(ptr_rd_data),
        .lut_o (lut_addr)
    );

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (ptr_rd_data == 16'h0 && lut_addr == 16'h0));
    // R7
    ptr_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr_wr_en && ptr_sel == 2'd2) |=> lut_addr == $past(ptr_wr_data));
    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !ptr_wr_en) |=> $stable(lut_addr));
    // R3
    byte_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !ptr_wr_en) |=> st_q.regs[$past(wr_sel)] == $past(wr_data));
    // R4
    null_ptr_chk: assert property (@(posedge clk) disable iff (rst)
        (ptr_sel == 2'd3) |-> ptr_rd_data == 16'h0);
endmodule

// File: tb/gpr_file_test.sv
module gpr_file_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst = 1;
    logic [4:0] rd_a_sel = 0, rd_b_sel = 0, wr_sel = 0;
    logic [7:0] rd_a_data, rd_b_data, wr_data = 0;
    logic wr_en = 0, ptr_wr_en = 0;
    logic [1:0] ptr_sel = 0;
    logic [15:0] ptr_rd_data, ptr_wr_data = 0, lut_addr;

    int total = 0, bad = 0;
    logic [7:0] m [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpr_file uut (.*);

    function automatic logic [15:0] mptr(input logic [1:0] s);
        if (s == 2'd3) return 16'h0;
        return {m[26 + 2*s + 1], m[26 + 2*s]};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // apply inputs after negedge, update model at posedge
    task automatic step();
        @(posedge clk);
        if (rst) foreach (m[i]) m[i] = 0;
        else begin
            if (wr_en) m[wr_sel] = wr_data;
            if (ptr_wr_en && ptr_sel != 3) begin
                m[26 + 2*ptr_sel]     = ptr_wr_data[7:0];
                m[26 + 2*ptr_sel + 1] = ptr_wr_data[15:8];
            end
        end
        @(negedge clk);
        wr_en = 0; ptr_wr_en = 0;
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 32; i++) begin
            rd_a_sel = 5'(i); rd_b_sel = 5'(31 - i); #1;
            chk(req, {8'h0, rd_a_data}, {8'h0, m[i]});
            chk(req, {8'h0, rd_b_data}, {8'h0, m[31-i]});
        end
        for (int p = 0; p < 4; p++) begin
            ptr_sel = 2'(p); #1;
            chk(req, ptr_rd_data, mptr(2'(p)));
        end
        chk("R8", lut_addr, {m[31], m[30]});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        foreach (m[i]) m[i] = 8'hxx;
        // load garbage then reset
        @(negedge clk); rst = 0;
        for (int i = 0; i < 32; i++) begin
            wr_en = 1; wr_sel = 5'(i); wr_data = 8'(i * 7 + 3); step();
        end
        rst = 1; step(); rst = 0;
        check_all("R1");

        // R2 same register both ports
        wr_en = 1; wr_sel = 5; wr_data = 8'hA5; step();
        rd_a_sel = 5; rd_b_sel = 5; #1;
        chk("R2", {8'h0, rd_a_data}, 16'h00A5);
        chk("R2", {8'h0, rd_b_data}, 16'h00A5);

        // R3 read-during-write returns old value
        rd_a_sel = 5; wr_en = 1; wr_sel = 5; wr_data = 8'h3C; #1;
        chk("R3", {8'h0, rd_a_data}, 16'h00A5);
        step(); #1;
        chk("R3", {8'h0, rd_a_data}, 16'h003C);

        // R5 byte writes show in pointer word
        wr_en = 1; wr_sel = 28; wr_data = 8'h34; step();
        wr_en = 1; wr_sel = 29; wr_data = 8'h12; step();
        ptr_sel = 1; #1;
        chk("R5", ptr_rd_data, 16'h1234);

        // R6 pointer write shows in bytes
        ptr_sel = 0; ptr_wr_en = 1; ptr_wr_data = 16'hBEEF; step();
        rd_a_sel = 26; rd_b_sel = 27; #1;
        chk("R6", {8'h0, rd_a_data}, 16'h00EF);
        chk("R6", {8'h0, rd_b_data}, 16'h00BE);

        // R4 code 3 write has no effect
        ptr_sel = 3; ptr_wr_en = 1; ptr_wr_data = 16'hFFFF; step();
        check_all("R4");

        // R7 collision, and non-colliding byte write
        ptr_sel = 2; ptr_wr_en = 1; ptr_wr_data = 16'hCAFE;
        wr_en = 1; wr_sel = 31; wr_data = 8'h11; step();
        chk("R7", lut_addr, 16'hCAFE);
        ptr_sel = 2; ptr_wr_en = 1; ptr_wr_data = 16'h0102;
        wr_en = 1; wr_sel = 7; wr_data = 8'h77; step();
        rd_a_sel = 7; #1;
        chk("R7", {8'h0, rd_a_data}, 16'h0077);
        chk("R8", lut_addr, 16'h0102);

        // R9 idle cycles
        step(); step();
        check_all("R9");

        // random mix
        for (int n = 0; n < 600; n++) begin
            wr_en = ($urandom % 3) != 0;
            wr_sel = ($urandom % 2) ? 5'(26 + $urandom % 6) : 5'($urandom);
            wr_data = 8'($urandom);
            ptr_wr_en = ($urandom % 3) == 0;
            ptr_sel = 2'($urandom);
            ptr_wr_data = 16'($urandom);
            step();
            rd_a_sel = 5'($urandom); rd_b_sel = 5'($urandom); ptr_sel = 2'($urandom); #1;
            chk("R2", {8'h0, rd_a_data}, {8'h0, m[rd_a_sel]});
            chk("R2", {8'h0, rd_b_data}, {8'h0, m[rd_b_sel]});
            chk("R5", ptr_rd_data, mptr(ptr_sel));
            chk("R8", lut_addr, {m[31], m[30]});
        end
        check_all("R6");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule